// File: doc/BRIEF.md
# Asynchronous Endpoint-FIFO Master for a USB 2.0 Bridge

This block lets FPGA logic on its own clock move bytes to and from a USB 2.0 bridge chip whose endpoint FIFOs run as an asynchronous slave. The FPGA is the bus master. The bridge's clock is unrelated to the FPGA clock, so no bridge signal is trusted until it has crossed into the FPGA clock domain. Every strobe the FPGA sends is a level that it holds for a set number of its own clocks. Two independent engines share the bridge bus. A reader pulls host-to-device bytes from the bulk-OUT endpoint at address `00`. A writer pushes measurement frames into the bulk-IN endpoint at address `10`.

On the user side, measurement bytes are written into an internal FIFO. A frame is sent only once all of its bytes are waiting in that FIFO. After the last byte of each frame the writer commits the packet with a packet-end strobe. The default frame is 504 bytes: 480 measurement bytes (240 two-byte results from a 16-electrode scan) plus header and footer bytes. Bytes read from the host appear as a one-cycle valid pulse with the byte.

The data bus is split into an input, an output and a drive enable, so the pad tri-state sits outside the block. The drive enable is high only while the write engine owns the bus. The bridge output enable is asserted only by the read engine.

Top module: `usbm_bridge_master`

## Requirements
- R1: While reset is held and on the first cycle after it, every strobe (`bus_rd_n`, `bus_wr_n`, `bus_oe_n`, `bus_pktend_n`) is high, `bus_dout_en` and `usr_rx_valid` are low, and `bus_addr` is `00`.
- R2: Bridge flags (active high: `bus_out_empty` = bulk-OUT empty, `bus_in_full` = bulk-IN full) pass through two flip-flops. With the block idle and no frame waiting, `bus_oe_n` first goes low on the third rising clock edge after `bus_out_empty` falls.
- R3: A read cycle drives `bus_addr` = `00`. It holds `bus_oe_n` low for exactly one cycle before `bus_rd_n` falls, holds `bus_rd_n` low for exactly STROBE_W cycles, and keeps `bus_oe_n` low for exactly GAP_W cycles after `bus_rd_n` rises.
- R4: The byte on `bus_din` is captured on the edge that releases `bus_rd_n`. `usr_rx_valid` is high for that one cycle with the byte on `usr_rx_data`, and bytes arrive in the order the bridge supplied them.
- R5: A read strobe starts only while the synchronized empty flag is low. The number of read strobes equals the number of bytes the bridge held, and none falls while the bridge is empty.
- R6: No write strobe occurs while fewer than FRAME_LEN bytes are waiting in the user FIFO.
- R7: A write cycle drives `bus_addr` = `10` and `bus_dout_en` high. Data is stable from the cycle before `bus_wr_n` falls until it rises. `bus_wr_n` is low for exactly STROBE_W cycles and is then high for at least GAP_W cycles.
- R8: No write strobe falls while the bulk-IN full flag is high. Writing resumes on its own once the flag clears, and no byte is lost or repeated.
- R9: After every FRAME_LEN-th byte written, `bus_pktend_n` is pulsed low for exactly STROBE_W cycles with `bus_addr` = `10`.
- R10: Only one engine owns the bus at a time. A read already started runs to its end. When a full frame is waiting at an arbitration point, the whole frame is written before the next read starts. `bus_dout_en` is never high while `bus_oe_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | FPGA clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_din | input | DATA_W | Data bus from the bridge |
| bus_dout | output | DATA_W | Data bus toward the bridge |
| bus_dout_en | output | 1 | Pad drive enable for `bus_dout` |
| bus_oe_n | output | 1 | Bridge output enable, active low |
| bus_rd_n | output | 1 | Bridge read strobe, active low |
| bus_wr_n | output | 1 | Bridge write strobe, active low |
| bus_pktend_n | output | 1 | Packet commit strobe, active low |
| bus_addr | output | 2 | Endpoint select: `00` bulk-OUT, `10` bulk-IN |
| bus_out_empty | input | 1 | Bulk-OUT empty flag (asynchronous) |
| bus_in_full | input | 1 | Bulk-IN full flag (asynchronous) |
| usr_wr_en | input | 1 | Push one byte into the user FIFO |
| usr_wr_data | input | DATA_W | Byte to push |
| usr_wr_full | output | 1 | User FIFO full; pushes are ignored |
| usr_rx_valid | output | 1 | Received byte valid, one cycle |
| usr_rx_data | output | DATA_W | Received byte |

## Verification
A single host byte arriving at an idle block exposes the flag latency and the order of output enable, strobe and release. A burst of bytes with distinct values shows that strobes match the bytes available and that order is kept. A frame one byte short, followed by its last byte, separates the frame-ready gate from a plain non-empty test. A full flag raised mid-frame shows stalling and lossless resumption. A frame that arrives while a long read burst is running separates write priority and whole-frame ownership from interleaving.

// File: rtl/usbm_pkg.sv
// Shared endpoint codes and engine state types for the bridge master.
// Assumes a two-bit endpoint select on the bridge bus.
package usbm_pkg;
    localparam logic [1:0] EP_ADDR_RD = 2'b00;
    localparam logic [1:0] EP_ADDR_WR = 2'b10;

    typedef enum logic [1:0] {RD_IDLE, RD_OE, RD_STB, RD_GAP} rd_state_e;

    typedef enum logic [2:0] {
        WR_IDLE, WR_WAIT, WR_SETUP, WR_STB, WR_GAP, WR_PKT, WR_PGAP
    } wr_state_e;
endpackage

// File: rtl/usbm_flag_sync.sv
// Two-flop synchronizer for a vector of independent level flags.
// Assumes every bit is a slow level whose bits need no mutual coherence.
module usbm_flag_sync #(
    parameter int W = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta;

    // Two register stages per flag bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta   <= RST_VAL;
            sync_o <= RST_VAL;
        end else begin
            meta   <= async_i;
            sync_o <= meta;
        end
    end
endmodule

// File: rtl/usbm_tx_fifo.sv
// Show-ahead user FIFO for outgoing bytes, with an occupancy count.
// Assumes pop is only raised while not empty; pushes while full are dropped.
module usbm_tx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 1024
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               push_data,
    input  logic                       pop,
    output logic [W-1:0]               head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       empty,
    output logic                       full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp];

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= push_data;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/usbm_rd_engine.sv
// Read engine: one bulk-OUT byte per grant.
// The cycle is: output enable, a stretched read strobe, then a held gap.
// Assumes GAP_W covers the bridge flag update plus two synchronizer stages.
module usbm_rd_engine #(
    parameter int W        = 8,
    parameter int STROBE_W = 3,
    parameter int GAP_W    = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic         empty_s,
    input  logic [W-1:0] bus_din,
    output logic         busy,
    output logic         oe_n,
    output logic         rd_n,
    output logic         rx_valid,
    output logic [W-1:0] rx_data
);
    import usbm_pkg::*;

    localparam int MAXW = (STROBE_W > GAP_W) ? STROBE_W : GAP_W;
    localparam int CW   = $clog2(MAXW + 1);

    rd_state_e     state;
    logic [CW-1:0] cnt;

    assign busy = (state != RD_IDLE);
    assign oe_n = (state == RD_IDLE);
    assign rd_n = (state != RD_STB);

    // Sequence one read and capture the byte when the strobe is released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RD_IDLE;
            cnt      <= '0;
            rx_valid <= 1'b0;
            rx_data  <= '0;
        end else begin
            rx_valid <= 1'b0;
            case (state)
                RD_IDLE: if (go) state <= RD_OE;
                RD_OE: begin
                    cnt   <= '0;
                    state <= empty_s ? RD_IDLE : RD_STB;
                end
                RD_STB: begin
                    if (cnt == CW'(STROBE_W - 1)) begin
                        state    <= RD_GAP;
                        cnt      <= '0;
                        rx_data  <= bus_din;
                        rx_valid <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RD_GAP: begin
                    if (cnt == CW'(GAP_W - 1)) state <= RD_IDLE;
                    else                       cnt   <= cnt + 1'b1;
                end
                default: state <= RD_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/usbm_wr_engine.sv
// Write engine: sends one frame of FRAME_LEN bytes, then a packet-end strobe.
// Waits before each byte while the synchronized full flag is high.
// Assumes the user FIFO held a whole frame when go was raised.
module usbm_wr_engine #(
    parameter int W         = 8,
    parameter int FRAME_LEN = 504,
    parameter int STROBE_W  = 3,
    parameter int GAP_W     = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic         full_s,
    input  logic         fifo_empty,
    input  logic [W-1:0] fifo_head,
    output logic         pop,
    output logic         busy,
    output logic         wr_n,
    output logic         pktend_n,
    output logic [W-1:0] dout,
    output logic         dout_en
);
    import usbm_pkg::*;

    localparam int MAXW = (STROBE_W > GAP_W) ? STROBE_W : GAP_W;
    localparam int CW   = $clog2(MAXW + 1);
    localparam int FW   = $clog2(FRAME_LEN + 1);

    wr_state_e     state;
    logic [CW-1:0] cnt;
    logic [FW-1:0] nbytes;

    assign pop      = (state == WR_WAIT) && !full_s && !fifo_empty;
    assign busy     = (state != WR_IDLE);
    assign dout_en  = busy;
    assign wr_n     = (state != WR_STB);
    assign pktend_n = (state != WR_PKT);

    // Frame sequencing: wait, set up data, strobe, gap, and finally commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= WR_IDLE;
            cnt    <= '0;
            nbytes <= '0;
            dout   <= '0;
        end else begin
            case (state)
                WR_IDLE: if (go) state <= WR_WAIT;
                WR_WAIT: if (pop) begin
                    dout  <= fifo_head;
                    state <= WR_SETUP;
                end
                WR_SETUP: begin
                    cnt   <= '0;
                    state <= WR_STB;
                end
                WR_STB: begin
                    if (cnt == CW'(STROBE_W - 1)) begin
                        cnt   <= '0;
                        state <= WR_GAP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                WR_GAP: begin
                    if (cnt == CW'(GAP_W - 1)) begin
                        cnt <= '0;
                        if (nbytes == FW'(FRAME_LEN - 1)) begin
                            nbytes <= '0;
                            state  <= WR_PKT;
                        end else begin
                            nbytes <= nbytes + 1'b1;
                            state  <= WR_WAIT;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                WR_PKT: begin
                    if (cnt == CW'(STROBE_W - 1)) begin
                        cnt   <= '0;
                        state <= WR_PGAP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                WR_PGAP: begin
                    if (cnt == CW'(GAP_W - 1)) state <= WR_IDLE;
                    else                       cnt   <= cnt + 1'b1;
                end
                default: state <= WR_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/usbm_bridge_master.sv
// Top of the asynchronous endpoint-FIFO master.
// It synchronizes the bridge flags, buffers outgoing bytes, and arbitrates the
// bridge bus between the read and write engines.
// Assumes TX_DEPTH >= FRAME_LEN, and that GAP_W exceeds the bridge flag delay
// plus two FPGA clocks.
module usbm_bridge_master #(
    parameter int DATA_W    = 8,
    parameter int FRAME_LEN = 504,
    parameter int TX_DEPTH  = 1024,
    parameter int STROBE_W  = 3,
    parameter int GAP_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_dout_en,
    output logic              bus_oe_n,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic              bus_pktend_n,
    output logic [1:0]        bus_addr,
    input  logic              bus_out_empty,
    input  logic              bus_in_full,
    input  logic              usr_wr_en,
    input  logic [DATA_W-1:0] usr_wr_data,
    output logic              usr_wr_full,
    output logic              usr_rx_valid,
    output logic [DATA_W-1:0] usr_rx_data
);
    import usbm_pkg::*;

    localparam int FCW = $clog2(TX_DEPTH + 1);

    logic              out_empty_s, in_full_s;
    logic              pop, fifo_empty;
    logic [DATA_W-1:0] fifo_head;
    logic [FCW-1:0]    fifo_cnt;
    logic              rd_busy, wr_busy, rd_go, wr_go, frame_ready, bus_free;

    usbm_flag_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({bus_out_empty, bus_in_full}),
        .sync_o  ({out_empty_s, in_full_s})
    );

    usbm_tx_fifo #(.W(DATA_W), .DEPTH(TX_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (usr_wr_en),
        .push_data (usr_wr_data),
        .pop       (pop),
        .head      (fifo_head),
        .count     (fifo_cnt),
        .empty     (fifo_empty),
        .full      (usr_wr_full)
    );

    // Arbitration: grants only while both engines are idle; a waiting frame wins.
    assign frame_ready = (fifo_cnt >= FCW'(FRAME_LEN));
    assign bus_free    = !rd_busy && !wr_busy;
    assign wr_go       = bus_free && frame_ready;
    assign rd_go       = bus_free && !frame_ready && !out_empty_s;
    assign bus_addr    = wr_busy ? EP_ADDR_WR : EP_ADDR_RD;

    usbm_rd_engine #(.W(DATA_W), .STROBE_W(STROBE_W), .GAP_W(GAP_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (rd_go),
        .empty_s  (out_empty_s),
        .bus_din  (bus_din),
        .busy     (rd_busy),
        .oe_n     (bus_oe_n),
        .rd_n     (bus_rd_n),
        .rx_valid (usr_rx_valid),
        .rx_data  (usr_rx_data)
    );

    usbm_wr_engine #(
        .W(DATA_W), .FRAME_LEN(FRAME_LEN), .STROBE_W(STROBE_W), .GAP_W(GAP_W)
    ) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (wr_go),
        .full_s     (in_full_s),
        .fifo_empty (fifo_empty),
        .fifo_head  (fifo_head),
        .pop        (pop),
        .busy       (wr_busy),
        .wr_n       (bus_wr_n),
        .pktend_n   (bus_pktend_n),
        .dout       (bus_dout),
        .dout_en    (bus_dout_en)
    );
endmodule

// File: rtl/usbm_bridge_master_chk.sv
// Protocol checker for the bridge master, attached to the top with bind.
// Pulse widths are measured with counters, not with long $past chains.
module usbm_bridge_master_chk #(
    parameter int DATA_W   = 8,
    parameter int STROBE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd_n,
    input logic              bus_wr_n,
    input logic              bus_pktend_n,
    input logic              bus_oe_n,
    input logic              bus_dout_en,
    input logic [DATA_W-1:0] bus_dout,
    input logic [1:0]        bus_addr,
    input logic              usr_rx_valid,
    input logic              rd_busy,
    input logic              wr_busy
);
    logic [15:0] rd_lo, wr_lo, pk_lo;

    // Count consecutive low cycles of each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_lo <= '0;
            wr_lo <= '0;
            pk_lo <= '0;
        end else begin
            rd_lo <= bus_rd_n     ? '0 : rd_lo + 1'b1;
            wr_lo <= bus_wr_n     ? '0 : wr_lo + 1'b1;
            pk_lo <= bus_pktend_n ? '0 : pk_lo + 1'b1;
        end
    end

    AST_RD_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_rd_n) |-> rd_lo == 16'(STROBE_W)); // R3
    AST_RD_UNDER_OE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> (!bus_oe_n && bus_addr == 2'b00)); // R3
    AST_RX_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        usr_rx_valid |-> $rose(bus_rd_n)); // R4
    AST_WR_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_wr_n) |-> wr_lo == 16'(STROBE_W)); // R7
    AST_WR_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr_n |-> (bus_addr == 2'b10 && bus_dout_en && $stable(bus_dout))); // R7
    AST_PKT_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_pktend_n) |-> (pk_lo == 16'(STROBE_W) && bus_addr == 2'b10)); // R9
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_dout_en && !bus_oe_n)); // R10
    AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_busy && wr_busy)); // R10
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!bus_rd_n, !bus_wr_n, !bus_pktend_n}) <= 1); // R10
endmodule

bind usbm_bridge_master usbm_bridge_master_chk #(
    .DATA_W(DATA_W), .STROBE_W(STROBE_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_rd_n     (bus_rd_n),
    .bus_wr_n     (bus_wr_n),
    .bus_pktend_n (bus_pktend_n),
    .bus_oe_n     (bus_oe_n),
    .bus_dout_en  (bus_dout_en),
    .bus_dout     (bus_dout),
    .bus_addr     (bus_addr),
    .usr_rx_valid (usr_rx_valid),
    .rd_busy      (rd_busy),
    .wr_busy      (wr_busy)
);

// File: tb/sim_usbm_bridge_master.sv
// Directed bench: behavioural bridge endpoints plus one task per scenario.
module sim_usbm_bridge_master;
    localparam int CLK_PERIOD = 20;
    localparam int DW   = 8;
    localparam int FLEN = 6;
    localparam int SW   = 3;
    localparam int GW   = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] bus_din, bus_dout, usr_wr_data, usr_rx_data;
    logic          bus_dout_en, bus_oe_n, bus_rd_n, bus_wr_n, bus_pktend_n;
    logic [1:0]    bus_addr;
    logic          bus_out_empty, bus_in_full;
    logic          usr_wr_en = 1'b0, usr_wr_full, usr_rx_valid;

    int n_checks = 0, n_fail = 0;

    // Bridge model state.
    logic [7:0] out_mem [256];
    logic [7:0] in_mem  [256];
    logic [7:0] tx_log  [256];
    logic [7:0] rx_mem  [256];
    int out_wr = 0, out_rd = 0, in_cnt = 0, in_room = 1000, tx_n = 0, rx_n = 0;
    int pkt_n = 0;
    int pkt_mark [16];

    // Monitor error counters.
    int rd_width_err = 0, oe_pre_err = 0, oe_gap_err = 0, rd_empty_err = 0;
    int wr_width_err = 0, wr_data_err = 0, wr_full_err = 0, pk_width_err = 0;
    int rd_in_frame_err = 0;
    bit frame_active = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign bus_out_empty = (out_wr == out_rd);
    assign bus_in_full   = (in_cnt >= in_room);
    assign bus_din       = out_mem[out_rd % 256];

    usbm_bridge_master #(
        .DATA_W(DW), .FRAME_LEN(FLEN), .TX_DEPTH(16), .STROBE_W(SW), .GAP_W(GW)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .bus_din(bus_din), .bus_dout(bus_dout),
        .bus_dout_en(bus_dout_en), .bus_oe_n(bus_oe_n), .bus_rd_n(bus_rd_n),
        .bus_wr_n(bus_wr_n), .bus_pktend_n(bus_pktend_n), .bus_addr(bus_addr),
        .bus_out_empty(bus_out_empty), .bus_in_full(bus_in_full),
        .usr_wr_en(usr_wr_en), .usr_wr_data(usr_wr_data), .usr_wr_full(usr_wr_full),
        .usr_rx_valid(usr_rx_valid), .usr_rx_data(usr_rx_data)
    );

    // Bulk-OUT endpoint: a byte leaves when the read strobe is released.
    always @(posedge bus_rd_n) if (rst_n) out_rd = out_rd + 1;
    // Bulk-IN endpoint: a byte is stored when the write strobe is released.
    always @(posedge bus_wr_n) if (rst_n) begin
        in_mem[in_cnt % 256] = bus_dout;
        in_cnt = in_cnt + 1;
    end
    // Packet commit marks the byte count at that point.
    always @(posedge bus_pktend_n) if (rst_n) begin
        pkt_mark[pkt_n % 16] = in_cnt;
        pkt_n = pkt_n + 1;
        frame_active = 1'b0;
    end
    always @(negedge bus_rd_n) if (rst_n) begin
        if (bus_out_empty) rd_empty_err++;
        if (frame_active) rd_in_frame_err++;
    end
    always @(negedge bus_wr_n) if (rst_n) begin
        if (bus_in_full) wr_full_err++;
        frame_active = 1'b1;
    end

    // Sampled monitor: strobe widths, enable framing, write data stability.
    int rd_run = 0, wr_run = 0, pk_run = 0, pre_run = 0, gap_run = 0;
    bit seen_rd = 1'b0;
    logic [DW-1:0] prev_dout = '0;
    always @(negedge clk) if (rst_n) begin
        if (!bus_rd_n) rd_run++;
        else if (rd_run != 0) begin if (rd_run != SW) rd_width_err++; rd_run = 0; end
        if (!bus_wr_n) wr_run++;
        else if (wr_run != 0) begin if (wr_run != SW) wr_width_err++; wr_run = 0; end
        if (!bus_pktend_n) pk_run++;
        else if (pk_run != 0) begin if (pk_run != SW) pk_width_err++; pk_run = 0; end
        if (!bus_oe_n && bus_rd_n && !seen_rd) pre_run++;
        if (!bus_rd_n) begin
            if (!seen_rd && pre_run != 1) oe_pre_err++;
            seen_rd = 1'b1;
        end
        if (!bus_oe_n && bus_rd_n && seen_rd) gap_run++;
        if (bus_oe_n) begin
            if (seen_rd && gap_run != GW) oe_gap_err++;
            seen_rd = 1'b0; pre_run = 0; gap_run = 0;
        end
        if (!bus_wr_n && (!bus_dout_en || bus_dout != prev_dout)) wr_data_err++;
        prev_dout = bus_dout;
        if (usr_rx_valid) begin rx_mem[rx_n % 256] = usr_rx_data; rx_n++; end
    end

    task automatic check(input string tag, input bit ok, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push_out(input logic [7:0] b);
        out_mem[out_wr % 256] = b;
        out_wr = out_wr + 1;
    endtask

    task automatic push_usr(input logic [7:0] b);
        @(negedge clk);
        usr_wr_en = 1'b1; usr_wr_data = b;
        tx_log[tx_n % 256] = b; tx_n++;
        @(negedge clk);
        usr_wr_en = 1'b0;
    endtask

    task automatic wait_rx(input int n);
        for (int i = 0; i < 2000 && rx_n < n; i++) @(negedge clk);
    endtask

    task automatic wait_pkt(input int n);
        for (int i = 0; i < 2000 && pkt_n < n; i++) @(negedge clk);
    endtask

    task automatic cmp_rx(input string tag);
        int bad = 0;
        for (int i = 0; i < rx_n; i++) if (rx_mem[i] != out_mem[i]) bad++;
        check(tag, bad == 0, bad, 0);
    endtask

    task automatic cmp_in(input string tag);
        int bad = 0;
        for (int i = 0; i < in_cnt; i++) if (in_mem[i] != tx_log[i]) bad++;
        check(tag, bad == 0, bad, 0);
    endtask

    task automatic t_reset();
        repeat (4) @(posedge clk);
        #1;
        check("R1 strobes high in reset", {bus_rd_n, bus_wr_n, bus_oe_n, bus_pktend_n} == 4'hF,
              {bus_rd_n, bus_wr_n, bus_oe_n, bus_pktend_n}, 15);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 strobes high after reset", {bus_rd_n, bus_wr_n, bus_oe_n, bus_pktend_n} == 4'hF,
              {bus_rd_n, bus_wr_n, bus_oe_n, bus_pktend_n}, 15);
        check("R1 outputs idle", !bus_dout_en && !usr_rx_valid && bus_addr == 2'b00,
              {bus_dout_en, usr_rx_valid, bus_addr}, 0);
    endtask

    task automatic t_flag_latency();
        @(negedge clk);
        push_out(8'hA5);
        @(posedge clk); @(posedge clk); #1;
        check("R2 oe held after two edges", bus_oe_n == 1'b1, bus_oe_n, 1);
        @(posedge clk); #1;
        check("R2 oe low on third edge", bus_oe_n == 1'b0, bus_oe_n, 0);
        check("R3 read address", bus_addr == 2'b00, bus_addr, 0);
        wait_rx(1);
        repeat (10) @(negedge clk);
        check("R4 single byte received", rx_n == 1, rx_n, 1);
        cmp_rx("R4 single byte value");
    endtask

    task automatic t_read_burst();
        @(negedge clk);
        push_out(8'h00); push_out(8'hFF); push_out(8'h3C); push_out(8'hC3); push_out(8'h81);
        wait_rx(6);
        repeat (40) @(negedge clk);
        check("R4 burst byte count", rx_n == 6, rx_n, 6);
        cmp_rx("R4 burst order and values");
        check("R5 strobes equal bytes", out_rd == out_wr, out_rd, out_wr);
        check("R5 no strobe while empty", rd_empty_err == 0, rd_empty_err, 0);
        check("R3 read strobe width", rd_width_err == 0, rd_width_err, 0);
        check("R3 oe lead and gap", oe_pre_err == 0 && oe_gap_err == 0,
              oe_pre_err + oe_gap_err, 0);
    endtask

    task automatic t_partial_frame();
        for (int i = 0; i < FLEN - 1; i++) push_usr(8'(8'h10 + i * 7));
        repeat (60) @(negedge clk);
        check("R6 no write before full frame", in_cnt == 0, in_cnt, 0);
        push_usr(8'hE7);
        wait_pkt(1);
        repeat (10) @(negedge clk);
        check("R6 frame written once complete", in_cnt == FLEN, in_cnt, FLEN);
        cmp_in("R7 written bytes match");
        check("R7 write strobe width", wr_width_err == 0, wr_width_err, 0);
        check("R7 data stable and driven", wr_data_err == 0, wr_data_err, 0);
        check("R9 packet end after frame", pkt_n == 1 && pkt_mark[0] == FLEN, pkt_mark[0], FLEN);
        check("R9 packet end width", pk_width_err == 0, pk_width_err, 0);
    endtask

    task automatic t_backpressure();
        int base = in_cnt;
        in_room = base + 2;
        for (int i = 0; i < FLEN; i++) push_usr(8'(8'h55 ^ (i * 13)));
        repeat (150) @(negedge clk);
        check("R8 stalls at full", in_cnt == base + 2, in_cnt, base + 2);
        check("R8 no strobe while full", wr_full_err == 0, wr_full_err, 0);
        check("R8 no commit during stall", pkt_n == 1, pkt_n, 1);
        in_room = 1000;
        wait_pkt(2);
        repeat (10) @(negedge clk);
        check("R8 frame resumes complete", in_cnt == base + FLEN, in_cnt, base + FLEN);
        cmp_in("R8 no byte lost or repeated");
        check("R9 second packet mark", pkt_mark[1] == 2 * FLEN, pkt_mark[1], 2 * FLEN);
    endtask

    task automatic t_priority();
        int rx0 = rx_n;
        int rx_at_pkt;
        @(negedge clk);
        for (int i = 0; i < 12; i++) push_out(8'(8'h90 + i));
        for (int i = 0; i < 30 && bus_oe_n; i++) @(negedge clk);
        for (int i = 0; i < FLEN; i++) push_usr(8'(8'h20 + i));
        wait_pkt(3);
        rx_at_pkt = rx_n;
        wait_rx(rx0 + 12);
        repeat (40) @(negedge clk);
        check("R10 write overtakes pending reads", rx_at_pkt < rx0 + 12, rx_at_pkt, rx0 + 11);
        check("R10 no read inside a frame", rd_in_frame_err == 0, rd_in_frame_err, 0);
        check("R10 all reads completed", rx_n == rx0 + 12, rx_n, rx0 + 12);
        cmp_rx("R10 read data intact");
        cmp_in("R10 frame data intact");
        check("R3 widths under contention", rd_width_err == 0 && oe_gap_err == 0,
              rd_width_err + oe_gap_err, 0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        usr_wr_data = '0;
        t_reset();
        t_flag_latency();
        t_read_burst();
        t_partial_frame();
        t_backpressure();
        t_priority();
        summary();
        $finish;
    end
endmodule